// File: doc/BRIEF.md
# Backup Battery Switchover Controller

This block decides which source feeds a backed-up output rail. It takes digitized samples of the main supply and the backup battery, both in millivolts, together with a single-cycle valid strobe. On each strobe it compares the two samples and selects the supply or the battery. The comparison uses two different margins: a narrow one while the supply is sagging and a wider one while it recovers. The 20 mV gap between the two margins stops the selection from chattering when the supply hovers near the battery level.

The selected source appears on a battery-on output and on a backup-mode flag. In backup mode the block drives the safe values that neighbouring supervisor logic expects. The power-fail output is held low. The watchdog status is held high. The low-line status is held low. The oscillator-select and oscillator-clock requests are blocked. Out of backup mode these signals pass straight through.

The same strobe also captures three more results. A power-fail comparison checks a third sampled voltage against a 1300 mV reference. Two battery range checks flag a battery below 2000 mV or above a top limit. That limit is 4250 mV, or 4000 mV for the low-threshold variant.

Top module: `backup_switch_ctrl`

## Requirements
- R1: While reset is asserted and after its release, until the first valid strobe, the block holds batteryOn=1, backupMode=1, pfOut=0, battLow=0 and battHigh=0.
- R2: When the supply is selected, a strobed sample with supplyMv < batteryMv + 50 selects the battery from the next clock edge. A difference of exactly 50 mV keeps the supply selected.
- R3: When the battery is selected, including the first strobe after reset, a strobed sample with supplyMv > batteryMv + 70 selects the supply from the next clock edge. A difference of exactly 70 mV keeps the battery selected.
- R4: The selection changes only on a clock edge where sampleValid=1. Between strobes it holds whatever the sample inputs do. A difference inside the 50..70 mV band never changes it.
- R5: batteryOn=1 when the battery feeds the rail and 0 when the supply does. backupMode always equals batteryOn.
- R6: Out of backup mode, pfOut is 0 if the last strobed pfiMv was below 1300 and 1 if it was 1300 or above. The value is updated at the strobe's edge.
- R7: In backup mode pfOut=0, wdoOut=1, lowLineOut=0, oscSelOut=0 and oscClkOut=0, whatever pfiMv, wdoIn, lowLineIn, oscSelIn and oscClkIn are. Out of backup mode, wdoOut, lowLineOut, oscSelOut and oscClkOut follow wdoIn, lowLineIn, oscSelIn and oscClkIn combinationally.
- R8: battLow=1 when the last strobed batteryMv was below 2000. battHigh=1 when it was above 4250, or above 4000 when LOW_VARIANT=1. Both flags update at the strobe's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe: the three samples are valid this cycle |
| supplyMv | input | MV_W | Main supply sample, mV |
| batteryMv | input | MV_W | Backup battery sample, mV |
| pfiMv | input | MV_W | Power-fail monitor sample, mV |
| wdoIn | input | 1 | Watchdog status from the watchdog block |
| lowLineIn | input | 1 | Low-line status from the reset block |
| oscSelIn | input | 1 | Oscillator-select request |
| oscClkIn | input | 1 | Oscillator clock request |
| batteryOn | output | 1 | 1 while the rail is fed from the battery |
| backupMode | output | 1 | Backup-mode flag for neighbouring blocks |
| pfOut | output | 1 | Power-fail status, low on failure or in backup |
| wdoOut | output | 1 | Watchdog status after backup forcing |
| lowLineOut | output | 1 | Low-line status after backup forcing |
| oscSelOut | output | 1 | Oscillator-select request after blocking |
| oscClkOut | output | 1 | Oscillator clock request after blocking |
| battLow | output | 1 | Last battery sample below 2000 mV |
| battHigh | output | 1 | Last battery sample above the top of the range |

## Verification
The source decision and the power-fail capture are both taken from the same strobe, so both can change on the same edge. The bench provokes this in two ways. First, it sends a recovering-supply sample while the battery is selected, once with the monitor voltage above 1300 mV and once below. It expects pfOut to show that very sample's comparison on the same edge that batteryOn falls. Second, it sends a sagging-supply sample with a healthy monitor voltage. It expects pfOut forced low on the same edge that batteryOn rises. The bench judges each case by sampling at the falling edge after the strobe.

// File: rtl/bbsw_pkg.sv
package bbsw_pkg;

  typedef enum logic {
    SRC_SUPPLY  = 1'b0,
    SRC_BATTERY = 1'b1
  } srcSel_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic belowFall;   // supply under battery + falling margin
    logic aboveRise;   // supply over battery + rising margin
  } cmpFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureFlags;
    logic backupActive;
  } ctrlStrobe_t;

endpackage

// File: rtl/bbsw_datapath.sv
module bbsw_datapath
  import bbsw_pkg::*;
#(
  parameter int MV_W        = 13,
  parameter int FALL_MV     = 50,
  parameter int RISE_MV     = 70,
  parameter int PF_REF_MV   = 1300,
  parameter int BATT_MIN_MV = 2000,
  parameter int BATT_MAX_MV = 4250
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [MV_W-1:0] supplyMv,
  input  logic [MV_W-1:0] batteryMv,
  input  logic [MV_W-1:0] pfiMv,
  input  logic            wdoIn,
  input  logic            lowLineIn,
  input  logic            oscSelIn,
  input  logic            oscClkIn,
  input  ctrlStrobe_t     strobe,
  output cmpFlags_t       cmp,
  output logic            pfOut,
  output logic            wdoOut,
  output logic            lowLineOut,
  output logic            oscSelOut,
  output logic            oscClkOut,
  output logic            battLow,
  output logic            battHigh
);

  // one spare bit so battery + margin never wraps
  localparam int CW = MV_W + 1;
  localparam logic [CW-1:0] FALL_C  = CW'(FALL_MV);
  localparam logic [CW-1:0] RISE_C  = CW'(RISE_MV);
  localparam logic [CW-1:0] PF_C    = CW'(PF_REF_MV);
  localparam logic [CW-1:0] BMIN_C  = CW'(BATT_MIN_MV);
  localparam logic [CW-1:0] BMAX_C  = CW'(BATT_MAX_MV);

  logic [CW-1:0] supplyExt;
  logic [CW-1:0] batteryExt;
  logic [CW-1:0] pfiExt;
  logic [CW-1:0] fallLimit;
  logic [CW-1:0] riseLimit;

  logic pfOkQ;
  logic battLowQ;
  logic battHighQ;

  assign supplyExt  = {1'b0, supplyMv};
  assign batteryExt = {1'b0, batteryMv};
  assign pfiExt     = {1'b0, pfiMv};
  assign fallLimit  = batteryExt + FALL_C;
  assign riseLimit  = batteryExt + RISE_C;

  always_comb begin
    cmp.belowFall = supplyExt < fallLimit;
    cmp.aboveRise = supplyExt > riseLimit;
  end

  // captured flags, loaded only on a sample strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfOkQ     <= 1'b0;
      battLowQ  <= 1'b0;
      battHighQ <= 1'b0;
    end else if (strobe.captureFlags) begin
      pfOkQ     <= pfiExt >= PF_C;
      battLowQ  <= batteryExt < BMIN_C;
      battHighQ <= batteryExt > BMAX_C;
    end
  end

  // backup forcing of status seen by neighbours
  always_comb begin
    if (strobe.backupActive) begin
      pfOut      = 1'b0;
      wdoOut     = 1'b1;
      lowLineOut = 1'b0;
      oscSelOut  = 1'b0;
      oscClkOut  = 1'b0;
    end else begin
      pfOut      = pfOkQ;
      wdoOut     = wdoIn;
      lowLineOut = lowLineIn;
      oscSelOut  = oscSelIn;
      oscClkOut  = oscClkIn;
    end
  end

  assign battLow  = battLowQ;
  assign battHigh = battHighQ;

endmodule

// File: rtl/bbsw_control.sv
module bbsw_control
  import bbsw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  cmpFlags_t   cmp,
  output ctrlStrobe_t strobe
);

  srcSel_t srcQ;
  srcSel_t srcNext;

  // reset lands in battery, so the first sample obeys the rising rule
  always_comb begin
    srcNext = srcQ;
    if (sampleValid) begin
      unique case (srcQ)
        SRC_SUPPLY:  if (cmp.belowFall) srcNext = SRC_BATTERY;
        SRC_BATTERY: if (cmp.aboveRise) srcNext = SRC_SUPPLY;
        default:     srcNext = SRC_BATTERY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcQ <= SRC_BATTERY;
    else       srcQ <= srcNext;
  end

  always_comb begin
    strobe.captureFlags = sampleValid;
    strobe.backupActive = (srcQ == SRC_BATTERY);
  end

endmodule

// File: rtl/backup_switch_ctrl.sv
module backup_switch_ctrl
  import bbsw_pkg::*;
#(
  parameter int MV_W        = 13,
  parameter int LOW_VARIANT = 0,
  parameter int FALL_MV     = 50,
  parameter int RISE_MV     = 70,
  parameter int PF_REF_MV   = 1300,
  parameter int BATT_MIN_MV = 2000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleValid,
  input  logic [MV_W-1:0] supplyMv,
  input  logic [MV_W-1:0] batteryMv,
  input  logic [MV_W-1:0] pfiMv,
  input  logic            wdoIn,
  input  logic            lowLineIn,
  input  logic            oscSelIn,
  input  logic            oscClkIn,
  output logic            batteryOn,
  output logic            backupMode,
  output logic            pfOut,
  output logic            wdoOut,
  output logic            lowLineOut,
  output logic            oscSelOut,
  output logic            oscClkOut,
  output logic            battLow,
  output logic            battHigh
);

  localparam int BATT_MAX_MV = (LOW_VARIANT != 0) ? 4000 : 4250;

  cmpFlags_t   cmp;
  ctrlStrobe_t strobe;

  bbsw_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .cmp         (cmp),
    .strobe      (strobe)
  );

  bbsw_datapath #(
    .MV_W        (MV_W),
    .FALL_MV     (FALL_MV),
    .RISE_MV     (RISE_MV),
    .PF_REF_MV   (PF_REF_MV),
    .BATT_MIN_MV (BATT_MIN_MV),
    .BATT_MAX_MV (BATT_MAX_MV)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .supplyMv   (supplyMv),
    .batteryMv  (batteryMv),
    .pfiMv      (pfiMv),
    .wdoIn      (wdoIn),
    .lowLineIn  (lowLineIn),
    .oscSelIn   (oscSelIn),
    .oscClkIn   (oscClkIn),
    .strobe     (strobe),
    .cmp        (cmp),
    .pfOut      (pfOut),
    .wdoOut     (wdoOut),
    .lowLineOut (lowLineOut),
    .oscSelOut  (oscSelOut),
    .oscClkOut  (oscClkOut),
    .battLow    (battLow),
    .battHigh   (battHigh)
  );

  assign batteryOn  = strobe.backupActive;
  assign backupMode = strobe.backupActive;

endmodule

// File: rtl/bbsw_checker.sv
module bbsw_checker #(
  parameter int MV_W      = 13,
  parameter int FALL_MV   = 50,
  parameter int RISE_MV   = 70,
  parameter int PF_REF_MV = 1300
) (
  input logic            clk,
  input logic            rstN,
  input logic            sampleValid,
  input logic [MV_W-1:0] supplyMv,
  input logic [MV_W-1:0] batteryMv,
  input logic [MV_W-1:0] pfiMv,
  input logic            batteryOn,
  input logic            backupMode,
  input logic            pfOut,
  input logic            wdoOut,
  input logic            lowLineOut,
  input logic            oscSelOut,
  input logic            oscClkOut
);

  localparam int CW = MV_W + 1;
  logic [CW-1:0] sE, bE;
  assign sE = {1'b0, supplyMv};
  assign bE = {1'b0, batteryMv};

  // R1: first edge out of reset still shows battery selected
  a_r1_reset_battery: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> batteryOn);

  // R2: sag below falling margin moves to battery
  a_r2_fall_switch: assert property (@(posedge clk) disable iff (!rstN)
    (!batteryOn && sampleValid && (sE < bE + CW'(FALL_MV))) |=> batteryOn);

  // R3: recovery above rising margin moves to supply
  a_r3_rise_switch: assert property (@(posedge clk) disable iff (!rstN)
    (batteryOn && sampleValid && (sE > bE + CW'(RISE_MV))) |=> !batteryOn);

  // R4: no strobe, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(batteryOn));

  // R5: flag tracks battery-on
  a_r5_mode_flag: assert property (@(posedge clk) disable iff (!rstN)
    backupMode == batteryOn);

  // R6: low monitor sample gives low power-fail output
  a_r6_pf_low: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ({1'b0, pfiMv} < CW'(PF_REF_MV))) |=> !pfOut);

  // R7: safe levels in backup
  a_r7_forced: assert property (@(posedge clk) disable iff (!rstN)
    batteryOn |-> (!pfOut && wdoOut && !lowLineOut && !oscSelOut && !oscClkOut));

endmodule

bind backup_switch_ctrl bbsw_checker #(
  .MV_W      (MV_W),
  .FALL_MV   (FALL_MV),
  .RISE_MV   (RISE_MV),
  .PF_REF_MV (PF_REF_MV)
) u_bbsw_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .supplyMv    (supplyMv),
  .batteryMv   (batteryMv),
  .pfiMv       (pfiMv),
  .batteryOn   (batteryOn),
  .backupMode  (backupMode),
  .pfOut       (pfOut),
  .wdoOut      (wdoOut),
  .lowLineOut  (lowLineOut),
  .oscSelOut   (oscSelOut),
  .oscClkOut   (oscClkOut)
);

// File: tb/test_backup_switch_ctrl.sv
`timescale 1ns/1ps
module test_backup_switch_ctrl;

  localparam int MV_W = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [MV_W-1:0] supplyMv = '0, batteryMv = '0, pfiMv = '0;
  logic wdoIn = 1'b0, lowLineIn = 1'b0, oscSelIn = 1'b0, oscClkIn = 1'b0;
  logic batteryOn, backupMode, pfOut, wdoOut, lowLineOut, oscSelOut, oscClkOut;
  logic battLow, battHigh;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  backup_switch_ctrl #(.MV_W(MV_W)) i_backup_switch_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .supplyMv(supplyMv), .batteryMv(batteryMv), .pfiMv(pfiMv),
    .wdoIn(wdoIn), .lowLineIn(lowLineIn), .oscSelIn(oscSelIn), .oscClkIn(oscClkIn),
    .batteryOn(batteryOn), .backupMode(backupMode), .pfOut(pfOut),
    .wdoOut(wdoOut), .lowLineOut(lowLineOut), .oscSelOut(oscSelOut),
    .oscClkOut(oscClkOut), .battLow(battLow), .battHigh(battHigh)
  );

  task automatic check(input string what, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", what, got, exp);
    end
  endtask

  // one strobed sample; results sampled at the following falling edge
  task automatic sample(input int s, input int b, input int p);
    @(negedge clk);
    supplyMv = MV_W'(s); batteryMv = MV_W'(b); pfiMv = MV_W'(p);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 batteryOn in reset", batteryOn, 1'b1);
    check("R1 pfOut in reset", pfOut, 1'b0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 batteryOn after release", batteryOn, 1'b1);
    check("R1 backupMode after release", backupMode, 1'b1);
    check("R1 battLow after release", battLow, 1'b0);
    check("R1 battHigh after release", battHigh, 1'b0);
  endtask

  task automatic t_first_sample;
    sample(3070, 3000, 1500);
    check("R3 first sample diff 70 keeps battery", batteryOn, 1'b1);
    sample(3071, 3000, 1500);
    check("R3 first sample diff 71 selects supply", batteryOn, 1'b0);
    check("R5 backupMode follows", backupMode, 1'b0);
    check("R6 pfOut high for 1500", pfOut, 1'b1);
  endtask

  task automatic t_fall_boundary;
    sample(3050, 3000, 1500);
    check("R2 diff 50 keeps supply", batteryOn, 1'b0);
    sample(3049, 3000, 1500);
    check("R2 diff 49 selects battery", batteryOn, 1'b1);
    check("R5 backupMode set", backupMode, 1'b1);
  endtask

  task automatic t_band_and_hold;
    sample(3060, 3000, 1500);
    check("R4 band from battery holds", batteryOn, 1'b1);
    sample(5000, 3000, 1500);
    check("R3 recover to supply", batteryOn, 1'b0);
    sample(3060, 3000, 1500);
    check("R4 band from supply holds", batteryOn, 1'b0);
    @(negedge clk);
    supplyMv = MV_W'(0); batteryMv = MV_W'(3000); pfiMv = MV_W'(0);
    repeat (3) @(negedge clk);
    check("R4 no strobe keeps supply", batteryOn, 1'b0);
    check("R4 no strobe keeps pfOut", pfOut, 1'b1);
  endtask

  task automatic t_power_fail;
    sample(5000, 3000, 1299);
    check("R6 pfi 1299 gives low", pfOut, 1'b0);
    sample(5000, 3000, 1300);
    check("R6 pfi 1300 gives high", pfOut, 1'b1);
  endtask

  task automatic t_forcing;
    @(negedge clk);
    wdoIn = 1'b0; lowLineIn = 1'b1; oscSelIn = 1'b1; oscClkIn = 1'b1;
    #1;
    check("R7 wdo passes in supply mode", wdoOut, 1'b0);
    check("R7 lowLine passes in supply mode", lowLineOut, 1'b1);
    check("R7 oscSel passes in supply mode", oscSelOut, 1'b1);
    check("R7 oscClk passes in supply mode", oscClkOut, 1'b1);
    sample(2000, 3000, 2000);
    check("R7 battery selected", batteryOn, 1'b1);
    check("R7 pfOut forced low", pfOut, 1'b0);
    check("R7 wdoOut forced high", wdoOut, 1'b1);
    check("R7 lowLineOut forced low", lowLineOut, 1'b0);
    check("R7 oscSelOut blocked", oscSelOut, 1'b0);
    check("R7 oscClkOut blocked", oscClkOut, 1'b0);
    wdoIn = 1'b1; lowLineIn = 1'b0; oscSelIn = 1'b0; oscClkIn = 1'b0;
  endtask

  task automatic t_same_edge;
    // battery -> supply with good monitor: pfOut rises with the same edge
    sample(5000, 3000, 1400);
    check("R3 same-edge switch to supply", batteryOn, 1'b0);
    check("R6 same-edge pfOut high", pfOut, 1'b1);
    sample(3040, 3000, 1400);
    check("R2 same-edge switch to battery", batteryOn, 1'b1);
    check("R7 same-edge pfOut forced", pfOut, 1'b0);
    sample(5000, 3000, 1200);
    check("R3 same-edge switch with low pfi", batteryOn, 1'b0);
    check("R6 same-edge pfOut low", pfOut, 1'b0);
  endtask

  task automatic t_battery_range;
    sample(5000, 1999, 1500);
    check("R8 batt 1999 low", battLow, 1'b1);
    check("R8 batt 1999 not high", battHigh, 1'b0);
    sample(5000, 2000, 1500);
    check("R8 batt 2000 not low", battLow, 1'b0);
    sample(5000, 4251, 1500);
    check("R8 batt 4251 high", battHigh, 1'b1);
    sample(5000, 4250, 1500);
    check("R8 batt 4250 not high", battHigh, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_sample();
    t_fall_boundary();
    t_band_and_hold();
    t_power_fail();
    t_forcing();
    t_same_edge();
    t_battery_range();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R4: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule